// File: doc/BRIEF.md
# Feedback Echo Stage

This block adds a recirculating echo to a stream of signed audio samples. It sits in a synthesizer's audio path just after the amplitude envelope. Each accepted sample is added to a scaled copy of an earlier output and the result is sent on. The result is also written into a ring buffer, so each echo feeds the next one and the repeats die away at a rate set by the feedback gain.

Two small parameter registers hold the echo distance, counted in samples, and the feedback gain. Each register can be loaded with a new value or stepped up and down by control pulses. Both clamp what they store. The gain magnitude therefore stays below unity, and the echo always decays instead of building up to full scale.

Top module: `fb_echo`

## Requirements
- R1: While `rst_n` is low and after it rises, `echo_out` is 0 and `echo_vld` is 0. Reset also sets the gain to 0, the delay to 1 and the write position to 0.
- R2: On a clock edge with `smp_vld` high, the block registers y = sat16(x + floor(g * t / 32768)). Here x is `smp_in`, g is the stored gain in signed Q1.15, and t is the stored output from D accepted samples earlier. The result appears on `echo_out` after that edge, and `echo_vld` is high for exactly that one cycle.
- R3: The history is a ring of 2^AW entries (256 by default), and the write position advances by one per accepted sample. D is counted in accepted samples, and the ring wraps so that delays up to 255 work indefinitely.
- R4: A history slot that has not been written since reset reads as 0.
- R5: A gain load stores `gain_val`, taken as signed, clamped into [-30720, +30720] (±0.9375).
- R6: A gain increment adds 2048 and a gain decrement subtracts 2048. Both saturate at ±30720.
- R7: A delay load stores `dly_val`, except that a value of 0 is stored as 1. The delay range is 1 to 255.
- R8: A delay increment adds one, up to a limit of 255. A delay decrement subtracts one, down to a limit of 1.
- R9: The sum saturates to [-32768, 32767] instead of wrapping.
- R10: On a cycle without `smp_vld`, `echo_out` holds its value, `echo_vld` is 0 and the history does not move.
- R11: Load has priority over increment, and increment has priority over decrement. A parameter change applies only to samples accepted on later edges. A sample on the same edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_in | input | 16 | Signed input sample |
| dly_ld | input | 1 | Load delay from `dly_val` |
| dly_inc | input | 1 | Step delay up by one |
| dly_dec | input | 1 | Step delay down by one |
| dly_val | input | 8 | Delay value to load |
| gain_ld | input | 1 | Load gain from `gain_val` |
| gain_inc | input | 1 | Step gain up |
| gain_dec | input | 1 | Step gain down |
| gain_val | input | 16 | Signed Q1.15 gain to load |
| echo_out | output | 16 | Signed output sample |
| echo_vld | output | 1 | Output strobe |

## Verification
The stimulus patterns each separate a different failure.

- A single impulse followed by silence gives a clean train of echoes. It exposes a wrong tap distance, a wrong shift or wrong rounding toward minus infinity.
- A long ramp-like sequence at the maximum delay runs the pointer around the ring several times. It catches wrap-around faults and leftover history that should read as zero.
- Full-scale positive and negative runs at the largest gain drive the sum into saturation. Extreme gain loads and repeated steps test the clamps.
- Sparse strobes and parameter pulses that coincide with samples show whether idle cycles disturb the history, and whether new settings take effect on the correct edge.

// File: rtl/fb_echo.sv
module fb_echo #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int GW    = 16,
  parameter int GMAX  = 30720,
  parameter int GSTEP = 2048
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_in,
  input  logic                 dly_ld,
  input  logic                 dly_inc,
  input  logic                 dly_dec,
  input  logic [AW-1:0]        dly_val,
  input  logic                 gain_ld,
  input  logic                 gain_inc,
  input  logic                 gain_dec,
  input  logic signed [GW-1:0] gain_val,
  output logic signed [DW-1:0] echo_out,
  output logic                 echo_vld
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] DMAX = AW'(DEPTH - 1);
  localparam logic [AW-1:0] DMIN = AW'(1);
  localparam logic signed [GW+1:0] GHI = (GW+2)'(GMAX);
  localparam logic signed [GW+1:0] GLO = -(GW+2)'(GMAX);
  localparam logic signed [GW+1:0] GST = (GW+2)'(GSTEP);
  localparam logic signed [DW+1:0] YHI = (DW+2)'((1 << (DW-1)) - 1);
  localparam logic signed [DW+1:0] YLO = -(DW+2)'(1 << (DW-1));

  logic signed [DW-1:0] ring [DEPTH];
  logic [DEPTH-1:0]     filled;
  logic [AW-1:0]        wptr, dly_q, raddr, dly_nx;
  logic signed [GW-1:0] gain_q;
  logic signed [GW+1:0] g_wide, g_ld, g_up, g_dn, g_nx;

  // tap, feedback product and saturated sum
  logic signed [DW-1:0]    tap;
  logic signed [GW+DW-1:0] prod;
  logic signed [DW:0]      fb;
  logic signed [DW+1:0]    sum;
  logic signed [DW-1:0]    y_nx;

  assign raddr = wptr - dly_q;
  assign tap   = filled[raddr] ? ring[raddr] : '0;
  assign prod  = gain_q * tap;
  assign fb    = (DW+1)'(prod >>> (GW-1));
  assign sum   = {{2{smp_in[DW-1]}}, smp_in} + {fb[DW], fb};
  assign y_nx  = (sum > YHI) ? YHI[DW-1:0] :
                 (sum < YLO) ? YLO[DW-1:0] : sum[DW-1:0];

  // gain register: load / step, clamped below unity
  assign g_wide = {{2{gain_q[GW-1]}}, gain_q};
  assign g_ld   = {{2{gain_val[GW-1]}}, gain_val};
  assign g_up   = g_wide + GST;
  assign g_dn   = g_wide - GST;

  always_comb begin
    if (gain_ld)       g_nx = (g_ld > GHI) ? GHI : (g_ld < GLO) ? GLO : g_ld;
    else if (gain_inc) g_nx = (g_up > GHI) ? GHI : g_up;
    else if (gain_dec) g_nx = (g_dn < GLO) ? GLO : g_dn;
    else               g_nx = g_wide;
  end

  // delay register: load / step, kept in 1..DEPTH-1
  always_comb begin
    if (dly_ld)       dly_nx = (dly_val == '0) ? DMIN : dly_val;
    else if (dly_inc) dly_nx = (dly_q == DMAX) ? DMAX : dly_q + 1'b1;
    else if (dly_dec) dly_nx = (dly_q == DMIN) ? DMIN : dly_q - 1'b1;
    else              dly_nx = dly_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      dly_q  <= DMIN;
    end else begin
      gain_q <= g_nx[GW-1:0];
      dly_q  <= dly_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      filled   <= '0;
      echo_out <= '0;
      echo_vld <= 1'b0;
    end else begin
      echo_vld <= smp_vld;
      if (smp_vld) begin
        wptr         <= wptr + 1'b1;
        filled[wptr] <= 1'b1;
        echo_out     <= y_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (smp_vld) ring[wptr] <= y_nx;
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> echo_vld);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!echo_vld && $stable(echo_out) && $stable(wptr)));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> wptr == AW'($past(wptr) + 1'b1));
  // R5
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q <= GMAX) && (gain_q >= -GMAX));
  // R7
  dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q != '0);
  // R11
  gain_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_ld && gain_val >= 0 && gain_val <= GMAX) |=> gain_q == $past(gain_val));
endmodule

// File: tb/test_fb_echo.sv
module test_fb_echo;
  logic clk = 0, rst_n = 0;
  logic smp_vld = 0;
  logic signed [15:0] smp_in = 0;
  logic dly_ld = 0, dly_inc = 0, dly_dec = 0;
  logic [7:0] dly_val = 0;
  logic gain_ld = 0, gain_inc = 0, gain_dec = 0;
  logic signed [15:0] gain_val = 0;
  logic signed [15:0] echo_out;
  logic echo_vld;

  always #2.5 clk = ~clk;

  fb_echo i_fb_echo (.clk, .rst_n, .smp_vld, .smp_in, .dly_ld, .dly_inc, .dly_dec,
    .dly_val, .gain_ld, .gain_inc, .gain_dec, .gain_val, .echo_out, .echo_vld);

  int checks = 0, errors = 0;
  bit done = 0;
  int hist [256];
  bit fill [256];
  int mwp = 0, mdly = 1, mg = 0, ey = 0, ev = 0;

  task automatic step(bit v, int x, bit dl, bit di, bit dd, int dv,
                      bit gl, bit gi, bit gd, int gv, string tag);
    int r, s, a;
    @(negedge clk);
    smp_vld = v; smp_in = 16'(x);
    dly_ld = dl; dly_inc = di; dly_dec = dd; dly_val = 8'(dv);
    gain_ld = gl; gain_inc = gi; gain_dec = gd; gain_val = 16'(gv);
    if (v) begin
      a = ((mwp - mdly) % 256 + 256) % 256;
      r = fill[a] ? hist[a] : 0;
      s = x + ((mg * r) >>> 15);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      hist[mwp] = s; fill[mwp] = 1; mwp = (mwp + 1) % 256;
      ey = s; ev = 1;
    end else ev = 0;
    if (gl) begin
      mg = int'(signed'(16'(gv)));
      if (mg > 30720) mg = 30720;
      if (mg < -30720) mg = -30720;
    end else if (gi) mg = (mg + 2048 > 30720) ? 30720 : mg + 2048;
    else if (gd) mg = (mg - 2048 < -30720) ? -30720 : mg - 2048;
    if (dl) mdly = (dv % 256 == 0) ? 1 : dv % 256;
    else if (di) mdly = (mdly == 255) ? 255 : mdly + 1;
    else if (dd) mdly = (mdly == 1) ? 1 : mdly - 1;
    @(posedge clk); #1;
    checks++;
    if (int'(echo_out) != ey || int'(echo_vld) != ev) begin
      errors++;
      $display("FAIL %s: out=%0d vld=%0d expected out=%0d vld=%0d", tag,
               echo_out, echo_vld, ey, ev);
    end
  endtask

  task automatic samp(int x, string tag);
    step(1, x, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic setg(int gv, string tag);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, gv, tag);
  endtask
  task automatic setd(int dv, string tag);
    step(0, 0, 1, 0, 0, dv, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin hist[i] = 0; fill[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (echo_out !== 0 || echo_vld !== 0) begin
      errors++;
      $display("FAIL R1: out=%0d vld=%0d expected 0 0", echo_out, echo_vld);
    end
    @(negedge clk); rst_n = 1;
    idle("R1");
    // defaults: gain 0 -> pass-through
    samp(1234, "R1"); samp(-777, "R2"); samp(0, "R2");
    // unwritten slots read zero, impulse echoes
    setg(16384, "R4"); setd(5, "R4");
    for (int i = 0; i < 4; i++) samp(100 * i, "R4");
    samp(10000, "R2");
    for (int i = 0; i < 25; i++) samp(0, "R2");
    // long wrap at maximum delay
    setd(255, "R3");
    for (int i = 0; i < 600; i++) samp((i * 37) % 2000 - 1000, "R3");
    // gain clamps
    setg(32767, "R5"); setd(3, "R5");
    samp(20000, "R5");
    for (int i = 0; i < 12; i++) samp(0, "R5");
    setg(-32768, "R5");
    samp(20000, "R5");
    for (int i = 0; i < 12; i++) samp(0, "R5");
    // steps
    setg(0, "R6");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    samp(16000, "R6");
    for (int i = 0; i < 8; i++) samp(0, "R6");
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    samp(16000, "R6");
    for (int i = 0; i < 8; i++) samp(0, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    samp(9000, "R6");
    for (int i = 0; i < 8; i++) samp(-50, "R6");
    // saturation
    setg(30720, "R9"); setd(1, "R9");
    for (int i = 0; i < 10; i++) samp(32767, "R9");
    for (int i = 0; i < 20; i++) samp(-32768, "R9");
    for (int i = 0; i < 10; i++) samp(30000, "R9");
    // delay clamps and steps
    setd(0, "R7"); setg(20000, "R7");
    samp(8000, "R7");
    for (int i = 0; i < 5; i++) samp(0, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
    samp(8000, "R8");
    for (int i = 0; i < 4; i++) samp(0, "R8");
    setd(254, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 300; i++) samp((i % 7) * 900 - 2700, "R8");
    setd(6, "R8");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 20; i++) samp((i == 0) ? 12000 : 0, "R8");
    // idle gaps
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 0) samp(500 * i - 4000, "R10"); else idle("R10");
    end
    // priority and same-edge timing
    step(0, 0, 1, 1, 1, 2, 1, 1, 1, 4096, "R11");
    samp(15000, "R11");
    for (int i = 0; i < 6; i++) samp(0, "R11");
    step(0, 0, 0, 1, 1, 0, 0, 1, 1, 0, "R11");
    samp(15000, "R11");
    for (int i = 0; i < 6; i++) samp(0, "R11");
    step(1, 7000, 1, 0, 0, 4, 1, 0, 0, -16384, "R11");
    for (int i = 0; i < 10; i++) samp(0, "R11");
    idle("R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule